// File: doc/BRIEF.md
# Sync Header Bit-Error-Rate Monitor

This block sits in the receive path of a 64b/66b link, after block alignment. Each cycle with a strobe carries one received block, and the block checks that block's 2-bit sync header. A legal header has two bits that differ. A header whose two bits are equal marks an errored block. Errored blocks are counted inside back-to-back timing windows of fixed length. If a single window collects a set number of them, which is 16 by default, the line error rate is judged too high. A short flag pulse then goes out, and the state machine enters its bad-header state.

Two statistics counters sit beside the monitor. One counts entries into the bad-header state. The other counts every errored block. Each counter saturates at its maximum value and has its own clear input. While the aligner reports no lock, the window timer and the window error count are held at zero, and no header is counted. Every port belongs to the receive clock domain.

Top module: `hdr_ber_monitor`

## Requirements
- R1: After reset, `highBer` is low and both `badEntryCnt` and `errBlkCnt` are zero.
- R2: A header counts as errored only when `blkValid` and `blkLock` are both high and `syncHdr` is 2'b00 or 2'b11. The values 2'b01 and 2'b10 are legal. Each errored header adds one to `errBlkCnt`, visible the cycle after it is sampled.
- R3: A header sampled while `blkValid` is low changes neither counter and adds nothing toward the window error count.
- R4: While `blkLock` is low, the window timer and the window error count stay at zero and no header is counted. After lock rises, a fresh window starts.
- R5: When the ERR_LIMIT-th errored header of one window is sampled, `highBer` rises on the next cycle.
- R6: Each time `highBer` fires, it stays high for exactly PULSE_CYCLES cycles (2 or 3). An error limit that is reached again while the pulse is active starts no new pulse.
- R7: A window lasts WIN_CYCLES locked cycles, and the next window starts right after it. The error count restarts from zero in each window, so errors split across two windows do not add up.
- R8: `badEntryCnt` goes up by one on each entry into the bad-header state, in the same cycle that `highBer` rises. This happens at most once per window.
- R9: `clrBadCnt` sets `badEntryCnt` to zero, and `clrErrBlk` sets `errBlkCnt` to zero, on the next cycle. Each clear wins over an increment in the same cycle and leaves the other counter alone.
- R10: Both statistics counters hold at all ones rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkValid | input | 1 | A block is present this cycle |
| syncHdr | input | 2 | Sync header of the present block |
| blkLock | input | 1 | Block alignment achieved |
| clrBadCnt | input | 1 | Clear the bad-state entry counter |
| clrErrBlk | input | 1 | Clear the errored-block counter |
| highBer | output | 1 | High error rate pulse |
| badEntryCnt | output | STAT_W | Entries into the bad-header state, saturating |
| errBlkCnt | output | STAT_W | Errored blocks seen, saturating |

## Verification
The bench uses a small configuration: a 20-cycle window, a limit of 4 and a 4-bit counter. It sweeps every header value with the strobe both high and low, which tells legal headers apart from errored ones and shows that unstrobed blocks are ignored. It also sweeps the number of errors (one to six) against the gap between them (zero to six cycles). Some of these bursts fit inside one window and some straddle a window boundary, so a trip is told apart from a near miss and from a count that leaks across windows. Other sequences drop lock in the middle of a burst, repeat the limit within one window, run a clear together with an increment, and drive enough errors to reach saturation.

// File: rtl/hdr_ber_pkg.sv
package hdr_ber_pkg;

  typedef struct packed {
    logic errSeen;   // errored header counted this cycle
    logic enterBad;  // state machine enters the bad-header state
  } ctlStrobes_t;

  typedef enum logic {
    ST_GOOD = 1'b0,
    ST_BAD  = 1'b1
  } berState_t;

endpackage

// File: rtl/hdr_ber_satcnt.sv
module hdr_ber_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    value <= '0;
    else if (clr)                 value <= '0;
    else if (inc && value != MAXV) value <= value + 1'b1;
  end
endmodule

// File: rtl/hdr_ber_datapath.sv
module hdr_ber_datapath
  import hdr_ber_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blkValid,
  input  logic [1:0]        syncHdr,
  input  logic              clrBadCnt,
  input  logic              clrErrBlk,
  input  ctlStrobes_t       strobes,
  output logic              hdrErr,
  output logic [STAT_W-1:0] badEntryCnt,
  output logic [STAT_W-1:0] errBlkCnt
);
  // equal bits (00 or 11) mean an illegal header
  assign hdrErr = blkValid && (syncHdr[1] == syncHdr[0]);

  hdr_ber_satcnt #(.W(STAT_W)) uBadEntry (
    .clk(clk), .rstN(rstN), .inc(strobes.enterBad), .clr(clrBadCnt), .value(badEntryCnt)
  );

  hdr_ber_satcnt #(.W(STAT_W)) uErrBlk (
    .clk(clk), .rstN(rstN), .inc(strobes.errSeen), .clr(clrErrBlk), .value(errBlkCnt)
  );
endmodule

// File: rtl/hdr_ber_ctrl.sv
module hdr_ber_ctrl
  import hdr_ber_pkg::*;
#(
  parameter int WIN_CYCLES   = 31250,
  parameter int ERR_LIMIT    = 16,
  parameter int PULSE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkLock,
  input  logic        hdrErr,
  output ctlStrobes_t strobes,
  output logic        highBer
);
  localparam int TMR_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam int PLS_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST  = TMR_W'(WIN_CYCLES - 1);
  localparam logic [ERR_W-1:0] ERR_TRIP  = ERR_W'(ERR_LIMIT - 1);
  localparam logic [ERR_W-1:0] ERR_FULL  = ERR_W'(ERR_LIMIT);
  localparam logic [PLS_W-1:0] PLS_START = PLS_W'(PULSE_CYCLES - 1);

  logic [TMR_W-1:0] winTmr;
  logic [ERR_W-1:0] winErr;
  logic [PLS_W-1:0] pulseLeft;
  berState_t        state;
  logic             winEnd, countIt, limitHit;

  assign countIt  = blkLock && hdrErr;
  assign winEnd   = blkLock && (winTmr == TMR_LAST);
  assign limitHit = countIt && (winErr == ERR_TRIP);

  assign strobes.errSeen  = countIt;
  assign strobes.enterBad = limitHit && (state == ST_GOOD);
  assign highBer          = (state == ST_BAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winTmr <= '0;
      winErr <= '0;
    end else if (!blkLock || winEnd) begin
      winTmr <= '0;
      winErr <= '0;
    end else begin
      winTmr <= winTmr + 1'b1;
      if (countIt && winErr != ERR_FULL) winErr <= winErr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_GOOD;
      pulseLeft <= '0;
    end else begin
      case (state)
        ST_GOOD: if (strobes.enterBad) begin
          state     <= ST_BAD;
          pulseLeft <= PLS_START;
        end
        ST_BAD: begin
          if (pulseLeft == '0) state <= ST_GOOD;
          else                 pulseLeft <= pulseLeft - 1'b1;
        end
        default: state <= ST_GOOD;
      endcase
    end
  end
endmodule

// File: rtl/hdr_ber_monitor.sv
module hdr_ber_monitor
  import hdr_ber_pkg::*;
#(
  parameter int WIN_CYCLES   = 31250,
  parameter int ERR_LIMIT    = 16,
  parameter int PULSE_CYCLES = 2,
  parameter int STAT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blkValid,
  input  logic [1:0]        syncHdr,
  input  logic              blkLock,
  input  logic              clrBadCnt,
  input  logic              clrErrBlk,
  output logic              highBer,
  output logic [STAT_W-1:0] badEntryCnt,
  output logic [STAT_W-1:0] errBlkCnt
);
  ctlStrobes_t strobes;
  logic        hdrErr;

  hdr_ber_ctrl #(
    .WIN_CYCLES(WIN_CYCLES), .ERR_LIMIT(ERR_LIMIT), .PULSE_CYCLES(PULSE_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .blkLock(blkLock), .hdrErr(hdrErr),
    .strobes(strobes), .highBer(highBer)
  );

  hdr_ber_datapath #(.STAT_W(STAT_W)) uData (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .syncHdr(syncHdr),
    .clrBadCnt(clrBadCnt), .clrErrBlk(clrErrBlk), .strobes(strobes),
    .hdrErr(hdrErr), .badEntryCnt(badEntryCnt), .errBlkCnt(errBlkCnt)
  );
endmodule

// File: rtl/hdr_ber_monitor_chk.sv
module hdr_ber_monitor_chk #(
  parameter int PULSE_CYCLES = 2,
  parameter int STAT_W       = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              blkValid,
  input logic              blkLock,
  input logic              clrBadCnt,
  input logic              clrErrBlk,
  input logic              highBer,
  input logic [STAT_W-1:0] badEntryCnt,
  input logic [STAT_W-1:0] errBlkCnt
);
  localparam logic [STAT_W-1:0] MAXV = '1;
  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runLen <= '0;
    else if (highBer) runLen <= runLen + 1'b1;
    else              runLen <= '0;
  end

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highBer) |=> highBer);  // R6
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 8'(PULSE_CYCLES));  // R6
  AST_NO_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blkLock && !clrErrBlk) |=> $stable(errBlkCnt));  // R4
  AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!blkValid && !clrErrBlk) |=> $stable(errBlkCnt));  // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrErrBlk |=> errBlkCnt == '0);  // R9
  AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrBadCnt |=> badEntryCnt == '0);  // R9
  AST_BAD_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (badEntryCnt == MAXV && !clrBadCnt) |=> badEntryCnt == MAXV);  // R10
  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (errBlkCnt == MAXV && !clrErrBlk) |=> errBlkCnt == MAXV);  // R10
  AST_ENTRY_COUNTED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(highBer) && !$past(clrBadCnt) && $past(badEntryCnt) != MAXV)
      |-> badEntryCnt == $past(badEntryCnt) + 1'b1);  // R8
endmodule

bind hdr_ber_monitor hdr_ber_monitor_chk #(
  .PULSE_CYCLES(PULSE_CYCLES), .STAT_W(STAT_W)
) uChk (
  .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkLock(blkLock),
  .clrBadCnt(clrBadCnt), .clrErrBlk(clrErrBlk), .highBer(highBer),
  .badEntryCnt(badEntryCnt), .errBlkCnt(errBlkCnt)
);

// File: tb/hdr_ber_monitor_test.sv
module hdr_ber_monitor_test;
  localparam int WIN = 20;
  localparam int LIM = 4;
  localparam int PLS = 2;
  localparam int SW  = 4;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkValid = 1'b0;
  logic [1:0] syncHdr = 2'b01;
  logic blkLock = 1'b0;
  logic clrBadCnt = 1'b0;
  logic clrErrBlk = 1'b0;
  logic highBer;
  logic [SW-1:0] badEntryCnt, errBlkCnt;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference state derived from the requirements
  int mTmr = 0, mErr = 0, mPulse = 0, mBad = 0, mBlk = 0;
  bit modelOn = 0;

  hdr_ber_monitor #(
    .WIN_CYCLES(WIN), .ERR_LIMIT(LIM), .PULSE_CYCLES(PLS), .STAT_W(SW)
  ) uut (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .syncHdr(syncHdr),
    .blkLock(blkLock), .clrBadCnt(clrBadCnt), .clrErrBlk(clrErrBlk),
    .highBer(highBer), .badEntryCnt(badEntryCnt), .errBlkCnt(errBlkCnt)
  );

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) begin
    if (modelOn) begin
      bit errHdr, counted, hit, wEnd;
      errHdr  = blkValid && (syncHdr == 2'b00 || syncHdr == 2'b11);
      counted = blkLock && errHdr;
      hit     = counted && (mErr == LIM - 1);
      wEnd    = blkLock && (mTmr == WIN - 1);
      if (!blkLock || wEnd) begin mTmr = 0; mErr = 0; end
      else begin mTmr++; if (counted && mErr < LIM) mErr++; end
      if (mPulse > 0) mPulse--;
      else if (hit) begin
        mPulse = PLS;
        if (mBad < SMAX) mBad++;
      end
      if (counted && mBlk < SMAX) mBlk++;
      if (clrBadCnt) mBad = 0;
      if (clrErrBlk) mBlk = 0;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("highBer", int'(highBer), (mPulse > 0) ? 1 : 0);
    check("badEntryCnt", int'(badEntryCnt), mBad);
    check("errBlkCnt", int'(errBlkCnt), mBlk);
  endtask

  // one cycle: compare after the last edge, then drive new inputs
  task automatic cyc(bit v, logic [1:0] h, bit lk, bit cb = 0, bit ce = 0);
    @(negedge clk);
    compareAll();
    blkValid = v; syncHdr = h; blkLock = lk; clrBadCnt = cb; clrErrBlk = ce;
  endtask

  task automatic idle(int n, bit lk = 1);
    for (int i = 0; i < n; i++) cyc(1, 2'b01, lk);
  endtask

  task automatic clearBoth();
    cyc(0, 2'b01, 1, 1, 1);
    idle(1);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("highBer", int'(highBer), 0);
    check("badEntryCnt", int'(badEntryCnt), 0);
    check("errBlkCnt", int'(errBlkCnt), 0);
    rstN = 1'b1;
    modelOn = 1;
    idle(2, 0);

    // R2: every header value, strobe high, spaced so no window trips
    curReq = "R2";
    for (int h = 0; h < 4; h++) begin
      idle(WIN, 0);
      idle(1);
      cyc(1, 2'(h), 1);
      idle(2);
      check("errBlk step", int'(errBlkCnt), (h == 0 || h == 3) ? 1 : 0);
      clearBoth();
    end

    // R3: illegal headers with strobe low are ignored
    curReq = "R3";
    for (int i = 0; i < 3 * WIN; i++) cyc(0, (i % 2) ? 2'b11 : 2'b00, 1);
    idle(1);
    check("errBlk unstrobed", int'(errBlkCnt), 0);
    check("badEntry unstrobed", int'(badEntryCnt), 0);

    // R4: no lock, nothing counted; lock loss clears window count
    curReq = "R4";
    for (int i = 0; i < 2 * WIN; i++) cyc(1, 2'b00, 0);
    idle(1, 0);
    check("errBlk unlocked", int'(errBlkCnt), 0);
    for (int i = 0; i < LIM - 1; i++) cyc(1, 2'b11, 1);
    idle(1, 0);
    for (int i = 0; i < LIM - 1; i++) cyc(1, 2'b11, 1);
    idle(PLS + 2);
    check("no trip across lock loss", int'(badEntryCnt), 0);
    clearBoth();

    // R5 / R7: sweep error count versus spacing from a window start
    curReq = "R5";
    for (int n = 1; n <= LIM + 2; n++) begin
      for (int gap = 0; gap <= 6; gap++) begin
        curReq = ((n - 1) * (gap + 1) + 1 > WIN) ? "R7" : "R5";
        idle(2, 0);
        for (int k = 0; k < n; k++) begin
          cyc(1, 2'b00, 1);
          if (k != n - 1) idle(gap);
        end
        idle(WIN + PLS);
        clearBoth();
      end
    end

    // R7: limit-1 errors at the end of one window and more in the next
    curReq = "R7";
    idle(2, 0);
    idle(WIN - (LIM - 1));
    for (int i = 0; i < LIM - 1; i++) cyc(1, 2'b11, 1);
    for (int i = 0; i < LIM - 1; i++) cyc(1, 2'b11, 1);
    idle(PLS + 2);
    check("split windows", int'(badEntryCnt), 0);
    clearBoth();

    // R6 / R8: limit reached twice within one window -> one entry
    curReq = "R8";
    idle(2, 0);
    for (int i = 0; i < 3 * LIM; i++) cyc(1, 2'b00, 1);
    idle(WIN);
    check("one entry per window", int'(badEntryCnt), 1);
    curReq = "R6";
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < LIM; i++) cyc(1, 2'b00, 1);
      idle(WIN);
    end
    clearBoth();

    // R9: clear coinciding with an increment, each clear separate
    curReq = "R9";
    idle(2, 0);
    for (int i = 0; i < LIM; i++) cyc(1, 2'b00, 1);
    idle(3);
    cyc(1, 2'b00, 1, 0, 1);
    idle(1);
    check("err cleared over inc", int'(errBlkCnt), 0);
    check("bad kept", int'(badEntryCnt), 1);
    cyc(1, 2'b11, 1, 1, 0);
    idle(1);
    check("bad cleared", int'(badEntryCnt), 0);
    check("err kept", int'(errBlkCnt), 1);
    clearBoth();

    // R10: saturation of both counters
    curReq = "R10";
    idle(2, 0);
    for (int w = 0; w < SMAX + 3; w++) begin
      for (int i = 0; i < LIM; i++) cyc(1, 2'b00, 1);
      idle(WIN - LIM);
    end
    idle(2);
    check("badEntry saturated", int'(badEntryCnt), SMAX);
    check("errBlk saturated", int'(errBlkCnt), SMAX);

    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule